// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block recovers characters from an asynchronous serial line. The raw input first passes through a two-flop synchronizer. It is then examined only on a one-cycle enable pulse that runs at sixteen times the bit rate. The line idles high. When a low level appears, a tick counter starts. The start bit is kept only if the line is still low at the eighth tick. Each later bit is decided one tick after its centre. The decision is a majority of three samples: one just before the centre, one at the centre and one just after it.

Word length (5 to 8 bits), parity enable and parity sense are static inputs. On the first stop bit, the block writes one 12-bit entry into a downstream receive buffer. That buffer reports when it is full. The entry holds the right-justified data and four status flags. A full buffer causes the character to be dropped, and the drop is remembered and reported in the next entry that is written. A line held low for a whole frame produces one break entry. After that, the receiver waits for the line to return high.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, and while the line stays high, wr_o stays low and no entry is written.
- R2: If the line is back high at the eighth tick after a falling edge is detected, the event is dropped. No entry is written and the receiver returns to idle, ready for the next start.
- R3: Data bits arrive LSB first. Their count is data_len_i + 5 (code 0 = 5 bits, up to code 3 = 8 bits). The character is right-justified in wr_data_o[7:0], and the unused upper bits are zero.
- R4: Each bit is the majority of three tick samples around its centre. A disturbance lasting one tick at a bit centre does not change the received value.
- R5: When parity_en_i is high, one parity bit follows the data. The expected bit is the XOR of the data bits, inverted when parity_odd_i is high. A mismatch sets wr_data_o[9].
- R6: A first stop bit sampled low sets wr_data_o[8]. Only one stop bit is checked.
- R7: A frame in which every bit, the stop bit included, is low writes exactly one entry of 12'h500: data zero, break flag in bit 10, framing flag in bit 8, parity flag clear. No further frame is accepted until the line returns high.
- R8: A character that completes while full_i is high is discarded. The next written entry carries wr_data_o[11] = 1, and the entry after that carries it clear again.
- R9: Each accepted frame produces exactly one wr_o pulse, one clock wide, with wr_data_o valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| data_len_i | input | 2 | Word length code: bits = code + 5 |
| parity_en_i | input | 1 | Expect a parity bit after the data |
| parity_odd_i | input | 1 | Odd parity when high, even when low |
| full_i | input | 1 | Downstream buffer is full |
| wr_o | output | 1 | Write strobe for one entry |
| wr_data_o | output | 12 | {overrun, break, parity error, framing error, data[7:0]} |

## Verification
The bench uses the default oversampling factor of 16 and two synchronizer stages. It drives tick_i every fourth clock, so one bit lasts 64 clocks. With this ratio each tick sample spans four clocks. A four-clock inversion placed at a bit centre therefore hits exactly one of the three votes, which exercises the majority decision directly. The same ratio makes a four-tick false start and a frame held fully low short enough to run next to normal, parity and overrun frames in one run.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned ENTRY_W = CHAR_W + 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              pe;
    logic              fe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
module rx_vote (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bit_i,
  output logic maj_o
);
  logic [1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= 2'b11;
    else if (tick_i) hist_q <= {hist_q[0], bit_i};
  end

  // samples: two earlier ticks plus the current one
  assign maj_o = (hist_q[1] & hist_q[0]) | (hist_q[1] & bit_i) | (hist_q[0] & bit_i);
endmodule

// File: rtl/rx_pack.sv
module rx_pack
  import serial_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              brk_i,
  input  logic              full_i,
  output logic              wr_o,
  output rx_entry_t         entry_o
);
  logic ovr_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o       <= 1'b0;
      entry_o    <= '0;
      ovr_pend_q <= 1'b0;
    end else begin
      wr_o <= 1'b0;
      if (done_i) begin
        if (full_i) begin
          ovr_pend_q <= 1'b1;
        end else begin
          wr_o          <= 1'b1;
          entry_o.ovr   <= ovr_pend_q;
          entry_o.brk   <= brk_i;
          entry_o.pe    <= pe_i & ~brk_i;
          entry_o.fe    <= fe_i;
          entry_o.data  <= brk_i ? '0 : data_i;
          ovr_pend_q    <= 1'b0;
        end
      end
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R9
  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_i) |=> !wr_o); // R8
  AST_BRK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && entry_o.brk) |-> (entry_o.data == '0 && entry_o.fe)); // R7
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rxd_i,
  input  logic [1:0]         data_len_i,
  input  logic               parity_en_i,
  input  logic               parity_odd_i,
  input  logic               full_i,
  output logic               wr_o,
  output logic [ENTRY_W-1:0] wr_data_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID_C = CW'(OVS / 2);
  localparam logic [CW-1:0] DEC_C = CW'(OVS / 2 + 1);

  logic rxd_s, maj;
  rx_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic par_q, low_q, pe_q;
  logic dec, done, brk;
  logic [IW-1:0] last_idx;
  logic [CHAR_W-1:0] data_rj;
  rx_entry_t entry;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s));

  rx_vote u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .bit_i(rxd_s), .maj_o(maj));

  assign dec      = tick_i && (cnt_q == DEC_C);
  assign last_idx = IW'(data_len_i) + IW'(CHAR_W - 4);
  assign done     = dec && (st_q == ST_STOP);
  assign brk      = low_q & ~maj;
  assign data_rj  = sh_q >> (IW'(3) - IW'(data_len_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      low_q <= 1'b0;
      pe_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (!rxd_s) begin
            cnt_q <= '0;
            st_q  <= ST_START;
          end
        end
        ST_START: begin
          if (cnt_q == MID_C && rxd_s) begin
            st_q <= ST_IDLE;
          end else if (cnt_q == DEC_C) begin
            st_q  <= ST_DATA;
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
            low_q <= 1'b1;
            pe_q  <= 1'b0;
          end
        end
        ST_DATA: begin
          if (dec) begin
            sh_q  <= {maj, sh_q[CHAR_W-1:1]};
            par_q <= par_q ^ maj;
            low_q <= low_q & ~maj;
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx) st_q <= parity_en_i ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (dec) begin
            pe_q  <= maj ^ par_q ^ parity_odd_i;
            low_q <= low_q & ~maj;
            st_q  <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (dec) st_q <= brk ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: begin
          if (rxd_s) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  rx_pack u_pack (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .data_i(data_rj),
    .pe_i(pe_q), .fe_i(~maj), .brk_i(brk), .full_i(full_i),
    .wr_o(wr_o), .entry_o(entry));

  assign wr_data_o = entry;

  AST_FALSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_START && tick_i && cnt_q == MID_C && rxd_s) |=> st_q == ST_IDLE); // R2
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && !rxd_s) |=> st_q == ST_HOLD); // R7
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> !wr_o); // R1
endmodule

// File: tb/serial_frame_rx_tb_top.sv
module serial_frame_rx_tb_top;
  localparam int BIT = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [1:0] len = 2'd3;
  logic pen = 1'b0, podd = 1'b0, full = 1'b0;
  logic wr;
  logic [11:0] wdat;
  int n_chk = 0, n_err = 0;
  int cap_n = 0;
  logic [11:0] cap [64];
  int tcnt = 0;

  always #10 clk = ~clk;

  serial_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .data_len_i(len), .parity_en_i(pen), .parity_odd_i(podd), .full_i(full),
    .wr_o(wr), .wr_data_o(wdat));

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick <= (tcnt == 0);
    if (rst_n && wr) begin
      cap[cap_n % 64] = wdat;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // gmask: data bits whose centre gets a one-tick inversion
  task automatic send(input logic [7:0] d, input int nb, input bit pbit, input bit use_par,
                      input bit stop, input logic [7:0] gmask);
    hold(1'b0, BIT);
    for (int i = 0; i < nb; i++) begin
      if (gmask[i]) begin
        hold(d[i], BIT/2 - 2);
        hold(~d[i], 4);
        hold(d[i], BIT/2 - 2);
      end else hold(d[i], BIT);
    end
    if (use_par) hold(pbit, BIT);
    hold(stop, BIT);
    hold(1'b1, 2*BIT);
  endtask

  task automatic expect_one(input string req, input int base, input logic [11:0] exp);
    chk({req, " count"}, 12'(cap_n - base), 12'd1);
    if (cap_n > base) chk(req, cap[base % 64], exp);
  endtask

  task automatic t_reset();
    int b = cap_n;
    hold(1'b1, 4*BIT);
    chk("R1 wr_o", {11'd0, wr}, 12'd0);
    chk("R1 count", 12'(cap_n - b), 12'd0);
  endtask

  task automatic t_false_start();
    int b = cap_n;
    hold(1'b0, 16);
    hold(1'b1, 3*BIT);
    chk("R2 no entry", 12'(cap_n - b), 12'd0);
    b = cap_n;
    len = 2'd3; pen = 0;
    send(8'hC3, 8, 0, 0, 1, 8'h00);
    expect_one("R2 next frame", b, 12'h0C3);
  endtask

  task automatic t_lengths();
    int b;
    pen = 0;
    b = cap_n; len = 2'd3; send(8'hA5, 8, 0, 0, 1, 8'h00); expect_one("R3 8b", b, 12'h0A5);
    b = cap_n; len = 2'd0; send(8'h13, 5, 0, 0, 1, 8'h00); expect_one("R3 5b", b, 12'h013);
    b = cap_n; len = 2'd1; send(8'h2A, 6, 0, 0, 1, 8'h00); expect_one("R3 6b", b, 12'h02A);
    b = cap_n; len = 2'd2; send(8'h5B, 7, 0, 0, 1, 8'h00); expect_one("R3 7b", b, 12'h05B);
  endtask

  task automatic t_vote();
    int b;
    len = 2'd3; pen = 0;
    b = cap_n; send(8'h96, 8, 0, 0, 1, 8'hFF); expect_one("R4 glitch all", b, 12'h096);
    b = cap_n; send(8'h0F, 8, 0, 0, 1, 8'h81); expect_one("R4 glitch ends", b, 12'h00F);
  endtask

  task automatic t_parity();
    int b;
    pen = 1; podd = 0; len = 2'd3;
    b = cap_n; send(8'h35, 8, 0, 1, 1, 8'h00); expect_one("R5 even ok", b, 12'h035);
    b = cap_n; send(8'h35, 8, 1, 1, 1, 8'h00); expect_one("R5 even bad", b, 12'h235);
    podd = 1; len = 2'd2;
    b = cap_n; send(8'h41, 7, 1, 1, 1, 8'h00); expect_one("R5 odd ok", b, 12'h041);
    b = cap_n; send(8'h41, 7, 0, 1, 1, 8'h00); expect_one("R5 odd bad", b, 12'h241);
    pen = 0; podd = 0; len = 2'd3;
  endtask

  task automatic t_framing();
    int b = cap_n;
    send(8'h55, 8, 0, 0, 0, 8'h00);
    expect_one("R6 stop low", b, 12'h155);
  endtask

  task automatic t_break();
    int b = cap_n;
    hold(1'b0, 12*BIT);
    expect_one("R7 break entry", b, 12'h500);
    hold(1'b0, 6*BIT);
    chk("R7 single entry", 12'(cap_n - b), 12'd1);
    hold(1'b1, 2*BIT);
    b = cap_n;
    send(8'h81, 8, 0, 0, 1, 8'h00);
    expect_one("R7 recover", b, 12'h081);
  endtask

  task automatic t_overrun();
    int b = cap_n;
    full = 1;
    send(8'h11, 8, 0, 0, 1, 8'h00);
    chk("R8 dropped", 12'(cap_n - b), 12'd0);
    full = 0;
    b = cap_n; send(8'h22, 8, 0, 0, 1, 8'h00); expect_one("R8 flagged", b, 12'h822);
    b = cap_n; send(8'h33, 8, 0, 0, 1, 8'h00); expect_one("R8 cleared", b, 12'h033);
  endtask

  task automatic t_pulse();
    int hi = 0;
    fork
      send(8'h7E, 8, 0, 0, 1, 8'h00);
      repeat (11*BIT) begin
        @(negedge clk);
        if (wr) hi++;
      end
    join
    chk("R9 pulse width", 12'(hi), 12'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset wr_o", {11'd0, wr}, 12'd0);
    rst_n = 1'b1;
    t_reset();
    t_false_start();
    t_lengths();
    t_vote();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    t_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule